// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block watches the leading bytes of each incoming Ethernet frame and decides, from the six-byte destination address alone, whether the receive path should keep the frame. It applies four classes in fixed priority. A promiscuous setting overrides everything. An all-ones destination is broadcast. Any other address with the group bit set is multicast. Everything else is unicast. Each class is gated by its own bit in an 8-bit receive-configuration input.

Multicast frames also pass through a 64-bin hash table. The bin is chosen by six bits of a CRC-32 that the block computes byte by byte while the address streams in. Unicast frames are compared against a programmed 48-bit station address.

Bytes arrive on a valid/ready stream with a start-of-frame marker. The block never applies back-pressure: `in_ready` is high whenever reset is released, and a byte counts only in a cycle with both `in_valid` and `in_ready` high. Idle cycles with `in_valid` low may fall anywhere between address bytes. The verdict is a plain one-cycle pulse with no handshake. Storing the frame and checking its own CRC belong to other blocks.

Top module: `daf_filter`

## Requirements
- R1: When `cfg_rx` bit 4 (promiscuous) is set at the sixth address byte, the decision accepts the frame, whatever its address.
- R2: A destination whose six bytes are all 0xFF is broadcast, reported as `dec_kind` 2. Without promiscuous mode it is accepted exactly when `cfg_rx` bit 2 is set.
- R3: A destination that is not broadcast and whose first byte has bit 0 set is multicast, reported as `dec_kind` 1. Without promiscuous mode it is accepted only when `cfg_rx` bit 3 is set and its hash bin in `mcast_table` is set.
- R4: The hash is computed as follows. A CRC-32 register starts at 0xFFFFFFFF for each frame. It uses polynomial 0x04C11DB7 and shifts in each byte least significant bit first: feedback is register bit 31 XOR the data bit, the register shifts left, and the polynomial is XORed in when the feedback is 1. There is no final inversion. The bin is register bits 31:26 after all six bytes. It selects table byte bin[5:3] and bit bin[2:0] within it, where table byte k sits at `mcast_table[8k+7:8k]`, so the bin is also the flat bit index.
- R5: Any other destination is unicast, reported as `dec_kind` 0. Without promiscuous mode it is accepted only if every byte matches `station_addr`: the first address byte is compared with bits 7:0 and byte k with bits 8k+7:8k.
- R6: `dec_valid` is high for exactly one cycle, the cycle after the sixth address byte is taken. `dec_accept` and `dec_kind` are valid in that cycle, and `dec_accept` is low whenever `dec_valid` is low.
- R7: A byte taken with `in_sof` high is address byte 0. It restarts both the byte count and the CRC, even partway through an address. Bytes after the sixth, and bytes that arrive without `in_sof` when no frame is open, are ignored and produce no decision.
- R8: `in_ready` is high whenever reset is released. Cycles with `in_valid` low between address bytes change neither the result nor the rule that the decision follows the sixth byte by one cycle.
- R9: While `rst` is high and after it is released, `dec_valid` and `dec_accept` are low and no frame is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Address byte present on `in_data` |
| in_ready | output | 1 | Byte can be taken; high outside reset |
| in_data | input | 8 | Frame byte |
| in_sof | input | 1 | Marks the first byte of a frame |
| cfg_rx | input | 8 | Receive configuration: bit 2 broadcast, bit 3 multicast, bit 4 promiscuous |
| station_addr | input | 48 | Station address, first wire byte in bits 7:0 |
| mcast_table | input | 64 | Multicast hash table, one bit per bin |
| dec_valid | output | 1 | One-cycle decision strobe |
| dec_accept | output | 1 | Frame accepted, valid with `dec_valid` |
| dec_kind | output | 2 | Address class: 0 unicast, 1 multicast, 2 broadcast |

## Verification
The embedded properties compare the verdict against the configuration value from the previous cycle, so they assume `cfg_rx` holds known values at the sixth address byte. They also assume `in_sof` is only meaningful together with `in_valid`. The stimulus changes configuration, station address and hash table only between frames, on the falling clock edge, and drives `in_sof` solely on the first byte it presents. Each hash bin used in the multicast cases comes from the bench's own CRC model, so a wrong polynomial, bit order or bin selection shows up as a wrong verdict.

// File: rtl/daf_pkg.sv
package daf_pkg;

  localparam int CFG_BCAST_BIT   = 2;
  localparam int CFG_MCAST_BIT   = 3;
  localparam int CFG_PROMISC_BIT = 4;

  typedef enum logic [1:0] {
    DA_UNICAST   = 2'd0,
    DA_MULTICAST = 2'd1,
    DA_BROADCAST = 2'd2
  } da_kind_e;

  // Advance a CRC-32 register by one byte, least significant bit first.
  function automatic logic [31:0] crc32_byte(input logic [31:0] state,
                                             input logic [7:0]  data,
                                             input logic [31:0] poly);
    logic [31:0] c;
    logic        fb;
    c = state;
    for (int i = 0; i < 8; i++) begin
      fb = c[31] ^ data[i];
      c  = {c[30:0], 1'b0};
      if (fb) c = c ^ poly;
    end
    return c;
  endfunction

endpackage

// File: rtl/daf_beat_tracker.sv
module daf_beat_tracker #(
  parameter int ADDR_BYTES = 6,
  localparam int CNT_W = $clog2(ADDR_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             beat,
  input  logic             sof,
  output logic             take,
  output logic             first,
  output logic             last,
  output logic [CNT_W-1:0] pos
);

  localparam logic [CNT_W-1:0] IDLE_POS = CNT_W'(ADDR_BYTES);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(ADDR_BYTES - 1);

  logic [CNT_W-1:0] cnt_q;

  assign pos   = sof ? '0 : cnt_q;
  assign take  = beat & (sof | (cnt_q < IDLE_POS));
  assign first = take & sof;
  assign last  = take & (pos == LAST_POS);

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= IDLE_POS;
    else if (take) cnt_q <= pos + 1'b1;
  end

  assert_count_bounded_R7: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= IDLE_POS);

  assert_restart_on_sof_R7: assert property (@(posedge clk) disable iff (rst)
    (beat && sof) |=> (cnt_q == CNT_W'(1)));

endmodule

// File: rtl/daf_crc_hash.sv
module daf_crc_hash
  import daf_pkg::*;
#(
  parameter int          HASH_BITS = 6,
  parameter logic [31:0] CRC_POLY  = 32'h04C11DB7,
  parameter logic [31:0] CRC_SEED  = 32'hFFFFFFFF
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 take,
  input  logic                 first,
  input  logic [7:0]           data,
  output logic [HASH_BITS-1:0] bin
);

  logic [31:0] crc_q;
  logic [31:0] crc_base;
  logic [31:0] crc_nxt;

  assign crc_base = first ? CRC_SEED : crc_q;
  assign crc_nxt  = crc32_byte(crc_base, data, CRC_POLY);
  assign bin      = crc_nxt[31 -: HASH_BITS];

  always_ff @(posedge clk) begin
    if (rst)       crc_q <= CRC_SEED;
    else if (take) crc_q <= crc_nxt;
  end

endmodule

// File: rtl/daf_addr_match.sv
module daf_addr_match #(
  parameter int ADDR_BYTES = 6,
  localparam int CNT_W  = $clog2(ADDR_BYTES + 1),
  localparam int ADDR_W = 8 * ADDR_BYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic              first,
  input  logic [CNT_W-1:0]  pos,
  input  logic [7:0]        data,
  input  logic [ADDR_W-1:0] station,
  output logic              bcast_now,
  output logic              group_now,
  output logic              ucast_now
);

  logic [ADDR_BYTES-1:0] byte_eq;
  logic                  bc_q, grp_q, uc_q;
  logic                  eq_sel;

  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_cmp
    assign byte_eq[g] = (data == station[8*g +: 8]);
  end

  assign eq_sel    = byte_eq[pos];
  assign bcast_now = (first | bc_q) & (&data);
  assign ucast_now = (first | uc_q) & eq_sel;
  assign group_now = first ? data[0] : grp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bc_q  <= 1'b0;
      grp_q <= 1'b0;
      uc_q  <= 1'b0;
    end else if (take) begin
      bc_q  <= bcast_now;
      grp_q <= group_now;
      uc_q  <= ucast_now;
    end
  end

endmodule

// File: rtl/daf_filter.sv
module daf_filter
  import daf_pkg::*;
#(
  parameter int          ADDR_BYTES = 6,
  parameter int          HASH_BITS  = 6,
  parameter logic [31:0] CRC_POLY   = 32'h04C11DB7,
  parameter logic [31:0] CRC_SEED   = 32'hFFFFFFFF,
  localparam int ADDR_W     = 8 * ADDR_BYTES,
  localparam int TABLE_BITS = 1 << HASH_BITS,
  localparam int CNT_W      = $clog2(ADDR_BYTES + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [7:0]            in_data,
  input  logic                  in_sof,
  input  logic [7:0]            cfg_rx,
  input  logic [ADDR_W-1:0]     station_addr,
  input  logic [TABLE_BITS-1:0] mcast_table,
  output logic                  dec_valid,
  output logic                  dec_accept,
  output logic [1:0]            dec_kind
);

  logic             beat, take, first, last;
  logic [CNT_W-1:0] pos;
  logic [HASH_BITS-1:0] bin;
  logic             bc_now, grp_now, uc_now;
  logic             is_mc, hit, acc;
  da_kind_e         kind;

  logic             valid_q, accept_q;
  da_kind_e         kind_q;

  assign in_ready = ~rst;
  assign beat     = in_valid & in_ready;

  daf_beat_tracker #(.ADDR_BYTES(ADDR_BYTES)) u_track (
    .clk(clk), .rst(rst), .beat(beat), .sof(in_sof),
    .take(take), .first(first), .last(last), .pos(pos)
  );

  daf_crc_hash #(.HASH_BITS(HASH_BITS), .CRC_POLY(CRC_POLY), .CRC_SEED(CRC_SEED)) u_hash (
    .clk(clk), .rst(rst), .take(take), .first(first), .data(in_data), .bin(bin)
  );

  daf_addr_match #(.ADDR_BYTES(ADDR_BYTES)) u_match (
    .clk(clk), .rst(rst), .take(take), .first(first), .pos(pos),
    .data(in_data), .station(station_addr),
    .bcast_now(bc_now), .group_now(grp_now), .ucast_now(uc_now)
  );

  assign is_mc = grp_now & ~bc_now;
  assign hit   = mcast_table[bin];
  assign kind  = bc_now ? DA_BROADCAST : (is_mc ? DA_MULTICAST : DA_UNICAST);

  always_comb begin
    unique case (kind)
      DA_BROADCAST: acc = cfg_rx[CFG_BCAST_BIT];
      DA_MULTICAST: acc = cfg_rx[CFG_MCAST_BIT] & hit;
      default:      acc = uc_now;
    endcase
    if (cfg_rx[CFG_PROMISC_BIT]) acc = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q  <= 1'b0;
      accept_q <= 1'b0;
      kind_q   <= DA_UNICAST;
    end else begin
      valid_q  <= last;
      accept_q <= last & acc;
      if (last) kind_q <= kind;
    end
  end

  assign dec_valid  = valid_q;
  assign dec_accept = accept_q;
  assign dec_kind   = kind_q;

  assert_pulse_after_last_R6: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> $past(last));

  assert_single_cycle_R6: assert property (@(posedge clk) disable iff (rst)
    dec_valid |=> !dec_valid);

  assert_quiet_accept_R6: assert property (@(posedge clk) disable iff (rst)
    !dec_valid |-> !dec_accept);

  assert_promisc_accepts_R1: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && $past(cfg_rx[CFG_PROMISC_BIT])) |-> dec_accept);

  assert_bcast_gated_R2: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && dec_kind == 2'd2 && !$past(cfg_rx[CFG_PROMISC_BIT])
     && !$past(cfg_rx[CFG_BCAST_BIT])) |-> !dec_accept);

  assert_mcast_gated_R3: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && dec_kind == 2'd1 && !$past(cfg_rx[CFG_PROMISC_BIT])
     && !$past(cfg_rx[CFG_MCAST_BIT])) |-> !dec_accept);

  assert_ready_out_of_reset_R8: assert property (@(posedge clk)
    !rst |-> in_ready);

endmodule

// File: tb/tb_daf_filter.sv
module tb_daf_filter;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid, in_sof;
  logic [7:0]  in_data;
  logic        in_ready;
  logic [7:0]  cfg_rx;
  logic [47:0] station_addr;
  logic [63:0] mcast_table;
  logic        dec_valid, dec_accept;
  logic [1:0]  dec_kind;

  int checks = 0;
  int fails  = 0;
  int pulses = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  daf_filter dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sof(in_sof), .cfg_rx(cfg_rx),
    .station_addr(station_addr), .mcast_table(mcast_table),
    .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_kind(dec_kind)
  );

  always @(posedge clk) if (!rst && dec_valid) pulses <= pulses + 1;

  localparam logic [47:0] STA   = 48'h55_44_33_22_11_02;
  localparam logic [47:0] BCAST = 48'hFF_FF_FF_FF_FF_FF;
  localparam logic [47:0] MC_A  = 48'hFB_00_00_5E_00_01;
  localparam logic [47:0] MC_B  = 48'h01_00_00_00_33_33;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // R4 hash model: seed all ones, LSB first, poly 0x04C11DB7, bits 31:26.
  function automatic logic [5:0] ref_bin(input logic [47:0] da);
    logic [31:0] c;
    logic        fb;
    c = 32'hFFFFFFFF;
    for (int b = 0; b < 6; b++)
      for (int i = 0; i < 8; i++) begin
        fb = c[31] ^ da[8*b + i];
        c  = {c[30:0], 1'b0};
        if (fb) c = c ^ 32'h04C11DB7;
      end
    return c[31:26];
  endfunction

  function automatic void ref_decide(input logic [47:0] da, output int acc, output int kind);
    bit bc, mc;
    bc = (da == BCAST);
    mc = da[0] && !bc;
    kind = bc ? 2 : (mc ? 1 : 0);
    if (bc)      acc = cfg_rx[2];
    else if (mc) acc = cfg_rx[3] && mcast_table[ref_bin(da)];
    else         acc = (da == station_addr);
    if (cfg_rx[4]) acc = 1;
  endfunction

  task automatic send_da(input logic [47:0] da, input int gap);
    for (int k = 0; k < 6; k++) begin
      in_valid = 1'b1;
      in_data  = da[8*k +: 8];
      in_sof   = (k == 0);
      @(negedge clk);
      if (gap > 0 && k < 5) begin
        in_valid = 1'b0;
        in_sof   = 1'b0;
        repeat (gap) @(negedge clk);
      end
    end
    in_valid = 1'b0;
    in_sof   = 1'b0;
  endtask

  task automatic check_frame(input string req, input logic [47:0] da, input int gap);
    int acc, kind, p0;
    ref_decide(da, acc, kind);
    p0 = pulses;
    send_da(da, gap);
    check({req, " dec_valid"}, dec_valid, 1);
    check({req, " dec_accept"}, dec_accept, acc);
    check({req, " dec_kind"}, dec_kind, kind);
    @(negedge clk);
    check({req, " pulse ends"}, dec_valid, 0);
    check({req, " accept low after"}, dec_accept, 0);
    check({req, " single pulse"}, pulses - p0, 1);
  endtask

  task automatic test_reset();
    check("R9 dec_valid in reset", dec_valid, 0);
    check("R9 dec_accept in reset", dec_accept, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R8 ready out of reset", in_ready, 1);
    check("R9 dec_valid after reset", dec_valid, 0);
  endtask

  task automatic test_unicast();
    cfg_rx = 8'h00;
    check_frame("R5 station match", STA, 0);
    check_frame("R5 last byte differs", STA ^ 48'h01_00_00_00_00_00, 0);
    check_frame("R5 first byte differs", STA ^ 48'h00_00_00_00_00_04, 0);
    check_frame("R5 middle byte differs", STA ^ 48'h00_00_80_00_00_00, 0);
  endtask

  task automatic test_broadcast();
    cfg_rx = 8'h00;
    check_frame("R2 broadcast disabled", BCAST, 0);
    cfg_rx = 8'h04;
    check_frame("R2 broadcast enabled", BCAST, 0);
    cfg_rx = 8'h08;
    mcast_table = '1;
    check_frame("R2 broadcast not multicast", BCAST, 0);
  endtask

  task automatic test_multicast();
    cfg_rx = 8'h00;
    mcast_table = '1;
    check_frame("R3 multicast disabled", MC_A, 0);
    cfg_rx = 8'h08;
    mcast_table = 64'h1 << ref_bin(MC_A);
    check_frame("R4 bin hit accepts", MC_A, 0);
    mcast_table = ~(64'h1 << ref_bin(MC_A));
    check_frame("R4 bin miss rejects", MC_A, 0);
    mcast_table = 64'h1 << ref_bin(MC_B);
    check_frame("R4 second address hit", MC_B, 0);
    mcast_table = 64'h0;
    check_frame("R3 empty table", MC_B, 0);
  endtask

  task automatic test_promisc();
    cfg_rx = 8'h10;
    mcast_table = 64'h0;
    check_frame("R1 foreign unicast", 48'h12_34_56_78_9A_BC, 0);
    check_frame("R1 broadcast", BCAST, 0);
    check_frame("R1 multicast", MC_A, 0);
  endtask

  task automatic test_gaps();
    cfg_rx = 8'h08;
    mcast_table = 64'h1 << ref_bin(MC_B);
    check_frame("R8 gaps multicast", MC_B, 2);
    cfg_rx = 8'h00;
    check_frame("R8 gaps unicast", STA, 3);
  endtask

  task automatic test_restart();
    int p0;
    cfg_rx = 8'h00;
    p0 = pulses;
    for (int k = 0; k < 3; k++) begin
      in_valid = 1'b1;
      in_data  = 8'hFF;
      in_sof   = (k == 0);
      @(negedge clk);
      check("R7 no decision mid address", dec_valid, 0);
    end
    check_frame("R7 restart on sof", STA, 0);
    check("R7 one decision after restart", pulses - p0, 1);
  endtask

  task automatic test_ignored();
    int p0;
    p0 = pulses;
    for (int k = 0; k < 8; k++) begin
      in_valid = 1'b1;
      in_data  = STA[8*(k % 6) +: 8];
      in_sof   = 1'b0;
      @(negedge clk);
      check("R7 trailing bytes ignored", dec_valid, 0);
    end
    in_valid = 1'b0;
    @(negedge clk);
    check("R7 no extra decision", pulses - p0, 0);
    check("R6 accept stays low", dec_accept, 0);
  endtask

  initial begin
    rst = 1'b1;
    in_valid = 1'b0;
    in_sof = 1'b0;
    in_data = 8'h00;
    cfg_rx = 8'h00;
    station_addr = STA;
    mcast_table = 64'h0;
    repeat (3) @(negedge clk);
    test_reset();
    test_ignored();
    test_unicast();
    test_broadcast();
    test_multicast();
    test_promisc();
    test_gaps();
    test_restart();
    test_ignored();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule